// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

The bridge gives a memory-mapped host register file a path into a PHY's indirect control-register port. Software never addresses a PHY register directly. It loads a value into a staging register and then starts one of four commands. Two of the commands pass the staged value to the PHY, one as the target register address and the other as pending write data. The third command commits the pending data to the captured address. The fourth fetches the register at the captured address into a result register.

Each command register reads back 1 while its operation runs and 0 once it has finished, and software polls it until it reads 0. On the PHY side, each command becomes a single request/acknowledge exchange that carries a 2-bit operation code and a 16-bit value. The bridge runs one command at a time. To write a PHY register, software issues capture-address, then capture-data, then commit. To read one, it issues capture-address, then fetch, and then reads the result register.

Top module: `phy_creg_bridge`

## Requirements
- R1: After reset, every command register reads 0, the result register (0x40) reads 0 and `phy_req_o` is low.
- R2: A host write to the staging register at offset 0x3C stores the low 16 bits of the bus data. A read of 0x3C returns them zero-extended to 32 bits.
- R3: Writing a 1 in bit 0 of offset 0x44 (capture address) raises `phy_req_o` on the next clock edge with `phy_op_o` = 0. `phy_data_o` then carries the staging value as it stood when the command started.
- R4: Writing a 1 in bit 0 of offset 0x48 (capture data) raises `phy_req_o` on the next clock edge with `phy_op_o` = 1. `phy_data_o` then carries the staging value as it stood when the command started.
- R5: Writing a 1 in bit 0 of offset 0x50 (commit write) raises `phy_req_o` on the next clock edge with `phy_op_o` = 2. After a capture address and a capture data, a later fetch of that address returns the committed data.
- R6: Writing a 1 in bit 0 of offset 0x4C (fetch) raises `phy_req_o` with `phy_op_o` = 3. The `phy_rdata_i` value present while `phy_ack_i` is first seen high is loaded into the result register at offset 0x40.
- R7: A command register reads 1 from the clock edge that starts its command until the operation completes, and reads 0 afterwards. At most one command register reads 1 at any time.
- R8: `phy_req_o` stays high until `phy_ack_i` is sampled high and drops on that edge. No new request is raised while `phy_ack_i` is still high, and `phy_data_o` stays stable while a request waits.
- R9: The running command completes, and its command register clears, on the clock edge at which `phy_ack_i` is first sampled low after the acknowledge. With a responder that answers in one cycle, a command register reads 1 for four cycles after the command starts and 0 in the fifth.
- R10: A command write that arrives while a command is running has no effect. It changes neither the PHY-side operation nor the data. It sets no command bit and causes no later PHY access. A write of 0 to a command register also has no effect.
- R11: The result register holds its value until the next fetch completes. The staging register can be rewritten while a command runs without changing `phy_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Host write strobe, one cycle per write |
| bus_addr_i | input | 8 | Host byte offset |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data, combinational on bus_addr_i |
| phy_req_o | output | 1 | Request strobe toward the PHY port |
| phy_op_o | output | 2 | Operation code: 0 address, 1 data, 2 write, 3 read |
| phy_data_o | output | 16 | Value sampled from the staging register at command start |
| phy_ack_i | input | 1 | Acknowledge from the PHY port |
| phy_rdata_i | input | 16 | Register contents returned on a read |

## Verification
The bench sweeps acknowledge and release latencies of the behavioural PHY responder over every combination in a small grid. For each combination it writes and reads back four PHY registers. A bridge that dropped the request early, or cleared a busy bit before the acknowledge fell, would corrupt or miss data in the longer-latency cases. A command issued into a running one must leave the op code, the data and the responder's access count unchanged, so a design that queued or overwrote commands shows up at the ports. The bench also counts the exact busy window against a one-cycle responder, rewrites the staging register during a pending request, and confirms that the result register survives address and data captures.

// File: rtl/phy_creg_pkg.sv
package phy_creg_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int N_CMD  = 4;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_DATA  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } creg_op_e;

  localparam logic [ADDR_W-1:0] OFS_DIN  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 8'h40;
  // command offsets indexed by op code
  localparam logic [ADDR_W-1:0] OFS_CMD [N_CMD] = '{8'h44, 8'h48, 8'h50, 8'h4C};
endpackage

// File: rtl/creg_host_regs.sv
module creg_host_regs
  import phy_creg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [N_CMD-1:0]  cmd_busy_i,
  input  logic              busy_i,
  output logic              start_o,
  output creg_op_e          start_op_o,
  output logic [DATA_W-1:0] din_o,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int PAD_W = BUS_W - DATA_W;

  logic [DATA_W-1:0] din_q, dout_q;
  logic [N_CMD-1:0]  cmd_hit;

  for (genvar k = 0; k < N_CMD; k++) begin : g_hit
    assign cmd_hit[k] = bus_we_i && bus_wdata_i[0] && (bus_addr_i == OFS_CMD[k]);
  end

  always_comb begin
    start_op_o = OP_ADDR;
    for (int k = 0; k < N_CMD; k++)
      if (cmd_hit[k]) start_op_o = creg_op_e'(k);
  end

  // commands landing during a busy operation are dropped
  assign start_o = (|cmd_hit) && !busy_i;
  assign din_o   = din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q  <= '0;
      dout_q <= '0;
    end else begin
      if (bus_we_i && bus_addr_i == OFS_DIN) din_q <= bus_wdata_i[DATA_W-1:0];
      if (rd_done_i) dout_q <= rd_data_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == OFS_DIN)  bus_rdata_o = {{PAD_W{1'b0}}, din_q};
    if (bus_addr_i == OFS_DOUT) bus_rdata_o = {{PAD_W{1'b0}}, dout_q};
    for (int k = 0; k < N_CMD; k++)
      if (bus_addr_i == OFS_CMD[k]) bus_rdata_o = {{(BUS_W-1){1'b0}}, cmd_busy_i[k]};
  end
endmodule

// File: rtl/creg_seq.sv
module creg_seq
  import phy_creg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  creg_op_e          op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic [N_CMD-1:0]  cmd_busy_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              phy_req_o,
  output logic [1:0]        phy_op_o,
  output logic [DATA_W-1:0] phy_data_o,
  input  logic              phy_ack_i,
  input  logic [DATA_W-1:0] phy_rdata_i
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_REL} state_e;

  state_e            state_q;
  creg_op_e          op_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_ADDR;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_REQ;
          op_q    <= op_i;
          data_q  <= data_i;
        end
        S_REQ:   if (phy_ack_i) state_q <= S_REL;
        S_REL:   if (!phy_ack_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != S_IDLE;
  assign phy_req_o  = state_q == S_REQ;
  assign phy_op_o   = op_q;
  assign phy_data_o = data_q;
  assign rd_done_o  = phy_req_o && phy_ack_i && op_q == OP_READ;
  assign rd_data_o  = phy_rdata_i;

  for (genvar k = 0; k < N_CMD; k++) begin : g_busy
    assign cmd_busy_o[k] = busy_o && (op_q == creg_op_e'(k));
  end
endmodule

// File: rtl/phy_creg_bridge.sv
module phy_creg_bridge
  import phy_creg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              phy_req_o,
  output logic [1:0]        phy_op_o,
  output logic [DATA_W-1:0] phy_data_o,
  input  logic              phy_ack_i,
  input  logic [DATA_W-1:0] phy_rdata_i
);
  logic              busy, start, rd_done;
  logic [N_CMD-1:0]  cmd_busy;
  creg_op_e          start_op;
  logic [DATA_W-1:0] din, rd_data;

  creg_host_regs i_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .cmd_busy_i(cmd_busy), .busy_i(busy), .start_o(start),
    .start_op_o(start_op), .din_o(din),
    .rd_done_i(rd_done), .rd_data_i(rd_data)
  );

  creg_seq i_seq (
    .clk_i, .rst_ni, .start_i(start), .op_i(start_op), .data_i(din),
    .busy_o(busy), .cmd_busy_o(cmd_busy), .rd_done_o(rd_done),
    .rd_data_o(rd_data), .phy_req_o, .phy_op_o, .phy_data_o,
    .phy_ack_i, .phy_rdata_i
  );
endmodule

// File: rtl/phy_creg_bridge_chk.sv
module phy_creg_bridge_chk
  import phy_creg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              phy_req_o,
  input logic              phy_ack_i,
  input logic [DATA_W-1:0] phy_data_o,
  input logic              busy,
  input logic [N_CMD-1:0]  cmd_busy
);
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_ack_i |=> phy_req_o);
  assert_req_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && phy_ack_i |=> !phy_req_o);
  assert_no_req_during_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_req_o && phy_ack_i |=> !phy_req_o);
  assert_data_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_ack_i |=> $stable(phy_data_o));
  assert_clear_after_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !phy_req_o && $fell(phy_ack_i) |=> !busy);
  assert_single_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_busy));
  assert_req_implies_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> $countones(cmd_busy) == 1);
endmodule

bind phy_creg_bridge phy_creg_bridge_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phy_req_o(phy_req_o), .phy_ack_i(phy_ack_i),
  .phy_data_o(phy_data_o), .busy(busy), .cmd_busy(cmd_busy)
);

// File: tb/test_phy_creg_bridge.sv
module test_phy_creg_bridge;
  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        req, ack;
  logic [1:0]  op;
  logic [15:0] pdata, prdata;

  int checks = 0, errors = 0;
  bit done = 0;
  int lat_ack = 0, lat_rel = 0, cnt = 0, accesses = 0;
  logic [15:0] mem [64];
  logic [5:0]  cap_addr;
  logic [15:0] cap_data;

  always #5 clk = ~clk;

  phy_creg_bridge i_phy_creg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .phy_req_o(req), .phy_op_o(op),
    .phy_data_o(pdata), .phy_ack_i(ack), .phy_rdata_i(prdata)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'h5A00 ^ (16'(i) * 16'h0101);
  endfunction

  // behavioural PHY responder
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 0; cnt <= 0; prdata <= 16'hFFFF;
    end else if (!ack) begin
      if (req) begin
        if (cnt >= lat_ack) begin
          ack <= 1; cnt <= 0; accesses <= accesses + 1;
          case (op)
            2'd0: cap_addr <= pdata[5:0];
            2'd1: cap_data <= pdata;
            2'd2: mem[cap_addr] <= cap_data;
            default: prdata <= mem[cap_addr];
          endcase
        end else cnt <= cnt + 1;
      end
    end else if (!req) begin
      if (cnt >= lat_rel) begin ack <= 0; cnt <= 0; end
      else cnt <= cnt + 1;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle(input logic [7:0] a, input string r);
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      bus_rd(a, d);
      if (d == 0) return;
      @(negedge clk);
    end
    chk(d, 0, r);
  endtask

  // issue command and check the PHY-side request one edge later
  task automatic issue(input logic [7:0] a, input logic [1:0] exp_op,
                       input logic [15:0] exp_d, input bit cmp_d, input string r);
    bus_wr(a, 1);
    chk({31'd0, req}, 1, r);
    chk({30'd0, op}, {30'd0, exp_op}, r);
    if (cmp_d) chk({16'd0, pdata}, {16'd0, exp_d}, r);
    wait_idle(a, "R7");
  endtask

  task automatic phy_write(input logic [15:0] a, input logic [15:0] v);
    bus_wr(8'h3C, {16'd0, a});
    issue(8'h44, 2'd0, a, 1, "R3");
    bus_wr(8'h3C, {16'd0, v});
    issue(8'h48, 2'd1, v, 1, "R4");
    issue(8'h50, 2'd2, 0, 0, "R5");
  endtask

  task automatic phy_read(input logic [15:0] a, output logic [31:0] d);
    bus_wr(8'h3C, {16'd0, a});
    issue(8'h44, 2'd0, a, 1, "R3");
    issue(8'h4C, 2'd3, 0, 0, "R6");
    bus_rd(8'h40, d);
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] pa [4];
    int acc0;
    pa[0] = 16'h1002; pa[1] = 16'h1006; pa[2] = 16'h1010; pa[3] = 16'h102D;
    for (int i = 0; i < 64; i++) mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk({31'd0, req}, 0, "R1");
    bus_rd(8'h40, d); chk(d, 0, "R1");
    bus_rd(8'h44, d); chk(d, 0, "R1");
    bus_rd(8'h48, d); chk(d, 0, "R1");
    bus_rd(8'h4C, d); chk(d, 0, "R1");
    bus_rd(8'h50, d); chk(d, 0, "R1");

    // R2 staging register
    bus_wr(8'h3C, 32'hDEAD_BEEF);
    bus_rd(8'h3C, d); chk(d, 32'h0000_BEEF, "R2");

    // R9 exact busy window with one-cycle responder
    bus_wr(8'h3C, 32'h1002);
    bus_wr(8'h44, 1);
    bus_rd(8'h44, d); chk(d, 1, "R9");
    repeat (3) @(negedge clk);
    bus_rd(8'h44, d); chk(d, 1, "R9");
    @(negedge clk);
    bus_rd(8'h44, d); chk(d, 0, "R9");

    // R6 fetch of an untouched register returns its reset contents
    phy_read(16'h1006, d);
    chk(d, {16'd0, init_val(6)}, "R6");

    // R5 sweep over responder latencies
    for (int la = 0; la < 4; la++)
      for (int lr = 0; lr < 3; lr++) begin
        lat_ack = la; lat_rel = lr;
        for (int k = 0; k < 4; k++)
          phy_write(pa[k], pa[k] ^ 16'(la << 12) ^ 16'(lr << 8) ^ 16'h0F0F);
        for (int k = 0; k < 4; k++) begin
          phy_read(pa[k], d);
          chk(d, {16'd0, pa[k] ^ 16'(la << 12) ^ 16'(lr << 8) ^ 16'h0F0F}, "R5");
        end
      end

    // R10 command while busy is ignored; R11 staging rewrite does not disturb data
    lat_ack = 6; lat_rel = 1;
    phy_read(16'h1010, d);
    bus_wr(8'h3C, 32'h102D);
    acc0 = accesses;
    bus_wr(8'h44, 1);
    bus_wr(8'h3C, 32'h1234);
    chk({16'd0, pdata}, 32'h102D, "R11");
    bus_wr(8'h4C, 1);
    bus_rd(8'h4C, d); chk(d, 0, "R10");
    bus_rd(8'h44, d); chk(d, 1, "R10");
    chk({30'd0, op}, 0, "R10");
    chk({16'd0, pdata}, 32'h102D, "R10");
    wait_idle(8'h44, "R10");
    repeat (12) @(negedge clk);
    chk(accesses - acc0, 1, "R10");
    chk({31'd0, req}, 0, "R10");
    bus_rd(8'h40, d);
    chk(d, {16'd0, 16'h1010 ^ 16'h3000 ^ 16'h0200 ^ 16'h0F0F}, "R11");

    // R10 write of 0 to a command register does nothing
    bus_wr(8'h50, 0);
    chk({31'd0, req}, 0, "R10");
    bus_rd(8'h50, d); chk(d, 0, "R10");

    // R11 result register survives captures, updates on next fetch
    bus_wr(8'h3C, 32'h102D);
    issue(8'h44, 2'd0, 16'h102D, 1, "R3");
    bus_rd(8'h40, d);
    chk(d, {16'd0, 16'h1010 ^ 16'h3000 ^ 16'h0200 ^ 16'h0F0F}, "R11");
    issue(8'h4C, 2'd3, 0, 0, "R6");
    bus_rd(8'h40, d);
    chk(d, {16'd0, 16'h102D ^ 16'h3000 ^ 16'h0200 ^ 16'h0F0F}, "R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule